// File: doc/BRIEF.md
# Transient Interrupt Window Trap Unit

This unit decides, for each instruction leaving a simple in-order core, whether a pending machine-level interrupt is taken at that point. It looks at the decoded fields of the retiring instruction, at the global interrupt-enable bit and the previous-enable bit supplied by the status register, and at a pending flag with its cause number. It returns a take-trap strobe, the next fetch address, and registered copies of the exception PC, the cause word and the two enable bits.

One encoding gets special treatment. It is a register-write access to the next-interrupt CSR with both the source and the destination register set to x0. This instruction changes no CSR and no register, so it retires as a no-op. For the single instruction that it occupies, however, pending interrupts at the same privilege are treated as enabled, even when the global enable bit is clear. Software can therefore give waiting interrupts a chance between two critical sections with one instruction, instead of setting and then clearing the enable bit. When the window is used, the saved PC points back at the window instruction, so that instruction runs again after the handler returns.

Top module: `irq_window_trap`

## Requirements
- R1: The window instruction is exactly this: opcode 7'b1110011, funct3 3'b001, CSR address equal to parameter NXTI_ADDR (default 12'h345), rd = 0 and rs1 = 0. A different register field, a different funct3, a different CSR address or a different opcode opens no window.
- R2: The window instruction does not drive `csr_fwd`. Any other valid instruction with opcode 7'b1110011 and a funct3 other than 3'b000 or 3'b100 drives `csr_fwd` high in the same cycle. All other instructions leave it low.
- R3: `trap_take` is high in the same cycle exactly when `ret_valid`, `irq_pending` and (`ie_in` or window) are all high.
- R4: Without a window and with `ie_in` low, a pending interrupt is held off. When no trap is taken, `next_pc` is `ret_pc + 4`, modulo 2^XLEN.
- R5: On the clock edge after a trap strobe, `epc_q` takes the `ret_pc` of the trapping instruction. For a window trap, this is the window instruction's own address.
- R6: On that edge, `pie_q` takes the real `ie_in` value, not the transient window value.
- R7: On that edge, `ie_q` is cleared and `cause_q` is loaded with bit XLEN-1 set and `irq_cause` in the low bits, with zeros between.
- R8: During a trap strobe, `next_pc` equals parameter HANDLER_BASE.
- R9: On an edge without a trap, `ie_q` and `pie_q` copy `ie_in` and `pie_in`, and `epc_q` and `cause_q` hold. A set enable bit therefore stays set across a window that takes no interrupt.
- R10: While `rst_n` is low at a clock edge, `epc_q`, `cause_q`, `ie_q` and `pie_q` become 0.
- R11: The window covers one instruction only. The instruction after it, with `ie_in` low, does not take a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_opcode | input | 7 | Opcode field of the retiring instruction |
| ret_funct3 | input | 3 | funct3 field |
| ret_csr | input | 12 | CSR address field |
| ret_rd | input | 5 | Destination register index |
| ret_rs1 | input | 5 | Source register index |
| ret_pc | input | XLEN | Address of the retiring instruction |
| ie_in | input | 1 | Current global interrupt enable |
| pie_in | input | 1 | Current previous-enable bit |
| irq_pending | input | 1 | A same-privilege interrupt is pending |
| irq_cause | input | CAUSE_W | Cause number of the pending interrupt |
| trap_take | output | 1 | Take the trap now (combinational strobe) |
| next_pc | output | XLEN | Next fetch address |
| csr_fwd | output | 1 | Hand this instruction to the normal CSR path |
| epc_q | output | XLEN | Saved exception PC |
| cause_q | output | XLEN | Saved cause word |
| ie_q | output | 1 | Updated global enable |
| pie_q | output | 1 | Updated previous-enable |

## Verification
The bench uses the default parameters: XLEN 32, CAUSE_W 4, NXTI_ADDR 12'h345 and HANDLER_BASE 32'h100. A 4-bit cause lets the bench use the extreme cause number 15 and check the 27 zero bits between it and the interrupt bit at position 31. With a 32-bit PC, a window instruction at 32'hFFFF_FFFC can be placed where PC+4 wraps to zero, and the bench can confirm that the saved PC still points at the window. The table also puts each near-miss encoding of the window (a nonzero rd, a nonzero rs1, another funct3, another address, another opcode) against a pending interrupt with the enable bit clear.

// File: rtl/tw_pkg.sv
// Package tw_pkg
// Shared encodings for the transient interrupt window trap unit.
// Assumes the standard 32-bit base encoding of system instructions.
package tw_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    typedef enum logic [2:0] {
        F3_PRIV   = 3'b000,
        F3_CSRRW  = 3'b001,
        F3_CSRRS  = 3'b010,
        F3_CSRRC  = 3'b011,
        F3_RSVD   = 3'b100,
        F3_CSRRWI = 3'b101,
        F3_CSRRSI = 3'b110,
        F3_CSRRCI = 3'b111
    } csr_f3_e;

    // True when funct3 names one of the six CSR access forms
    function automatic logic is_csr_form(input logic [2:0] f3);
        return (f3 != F3_PRIV) && (f3 != F3_RSVD);
    endfunction

endpackage

// File: rtl/tw_decode.sv
// Module tw_decode
// Classifies the retiring instruction. It spots the transient-window
// encoding and flags every other CSR access for the normal CSR path.
// Assumes the fields are already split out by the decoder; purely combinational.
module tw_decode
    import tw_pkg::*;
#(
    parameter logic [11:0] NXTI_ADDR = 12'h345
) (
    input  logic        valid,
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    input  logic [11:0] csr,
    input  logic [4:0]  rd,
    input  logic [4:0]  rs1,
    output logic        win_hit,
    output logic        csr_fwd
);
    logic is_sys;

    // Classify: window form versus ordinary CSR access
    always_comb begin
        is_sys  = valid && (opcode == OPC_SYSTEM);
        win_hit = is_sys && (funct3 == F3_CSRRW) && (csr == NXTI_ADDR)
                  && (rd == 5'd0) && (rs1 == 5'd0);
        csr_fwd = is_sys && is_csr_form(funct3) && !win_hit;
    end

endmodule

// File: rtl/tw_decide.sv
// Module tw_decide
// Combinational trap decision: interrupts are enabled either by the
// global bit or, for one instruction only, by the window encoding.
// Assumes the handler base is fixed by parameter.
module tw_decide #(
    parameter int          XLEN         = 32,
    parameter logic [XLEN-1:0] HANDLER_BASE = 'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            win_hit,
    input  logic            ie_in,
    input  logic            pending,
    input  logic [XLEN-1:0] pc,
    output logic            trap_take,
    output logic [XLEN-1:0] next_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic eff_enable;

    // Effective enable and redirect choice
    always_comb begin
        eff_enable = ie_in || win_hit;
        trap_take  = valid && pending && eff_enable;
        next_pc    = trap_take ? HANDLER_BASE : pc + STEP;
    end

    // R3
    trap_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> (valid && pending));

    // R4
    held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_in && !win_hit) |-> !trap_take);

endmodule

// File: rtl/tw_state.sv
// Module tw_state
// Registers for exception PC, cause word and the two enable bits.
// Assumes the trap strobe is valid for one cycle; capture on the next edge.
module tw_state #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_take,
    input  logic [XLEN-1:0]    pc,
    input  logic               ie_in,
    input  logic               pie_in,
    input  logic [CAUSE_W-1:0] cause_id,
    output logic [XLEN-1:0]    epc_q,
    output logic [XLEN-1:0]    cause_q,
    output logic               ie_q,
    output logic               pie_q
);
    localparam int PAD_W = XLEN - 1 - CAUSE_W;

    logic [XLEN-1:0] cause_word;

    // Build the cause word: interrupt bit on top, cause number at the bottom
    generate
        if (PAD_W > 0) begin : g_pad
            assign cause_word = {1'b1, {PAD_W{1'b0}}, cause_id};
        end else begin : g_tight
            assign cause_word = {1'b1, cause_id[XLEN-2:0]};
        end
    endgenerate

    // Capture trap state, or copy the status bits through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            ie_q    <= 1'b0;
            pie_q   <= 1'b0;
        end else if (trap_take) begin
            epc_q   <= pc;
            cause_q <= cause_word;
            ie_q    <= 1'b0;
            pie_q   <= ie_in;
        end else begin
            ie_q    <= ie_in;
            pie_q   <= pie_in;
        end
    end

    // R5
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (epc_q == $past(pc)));

    // R6
    pie_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (pie_q == $past(ie_in)));

    // R7
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!ie_q && cause_q[XLEN-1]
                       && (cause_q[CAUSE_W-1:0] == $past(cause_id))));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take |=> ($stable(epc_q) && $stable(cause_q)
                        && (ie_q == $past(ie_in))));

endmodule

// File: rtl/irq_window_trap.sv
// Module irq_window_trap
// Top of the transient interrupt window trap unit: decode, decision, state.
// Assumes one retiring instruction per cycle at most, machine mode only.
module irq_window_trap #(
    parameter int              XLEN         = 32,
    parameter int              CAUSE_W      = 4,
    parameter logic [11:0]     NXTI_ADDR    = 12'h345,
    parameter logic [XLEN-1:0] HANDLER_BASE = 'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_valid,
    input  logic [6:0]         ret_opcode,
    input  logic [2:0]         ret_funct3,
    input  logic [11:0]        ret_csr,
    input  logic [4:0]         ret_rd,
    input  logic [4:0]         ret_rs1,
    input  logic [XLEN-1:0]    ret_pc,
    input  logic               ie_in,
    input  logic               pie_in,
    input  logic               irq_pending,
    input  logic [CAUSE_W-1:0] irq_cause,
    output logic               trap_take,
    output logic [XLEN-1:0]    next_pc,
    output logic               csr_fwd,
    output logic [XLEN-1:0]    epc_q,
    output logic [XLEN-1:0]    cause_q,
    output logic               ie_q,
    output logic               pie_q
);
    logic win_hit;

    tw_decode #(.NXTI_ADDR(NXTI_ADDR)) i_decode (
        .valid   (ret_valid),
        .opcode  (ret_opcode),
        .funct3  (ret_funct3),
        .csr     (ret_csr),
        .rd      (ret_rd),
        .rs1     (ret_rs1),
        .win_hit (win_hit),
        .csr_fwd (csr_fwd)
    );

    tw_decide #(.XLEN(XLEN), .HANDLER_BASE(HANDLER_BASE)) i_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (ret_valid),
        .win_hit   (win_hit),
        .ie_in     (ie_in),
        .pending   (irq_pending),
        .pc        (ret_pc),
        .trap_take (trap_take),
        .next_pc   (next_pc)
    );

    tw_state #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_take (trap_take),
        .pc        (ret_pc),
        .ie_in     (ie_in),
        .pie_in    (pie_in),
        .cause_id  (irq_cause),
        .epc_q     (epc_q),
        .cause_q   (cause_q),
        .ie_q      (ie_q),
        .pie_q     (pie_q)
    );

    // R2
    window_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> !csr_fwd);

    // R8
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> (next_pc == HANDLER_BASE));

endmodule

// File: tb/test_irq_window_trap.sv
// Bench for irq_window_trap: a vector table walked by one loop,
// followed by directed reset and corner tests.
module test_irq_window_trap;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h100;

    typedef struct packed {
        logic [6:0]  opc;
        logic [2:0]  f3;
        logic [11:0] csr;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic        ie;
        logic        pie;
        logic        pend;
        logic [3:0]  cause;
        logic [31:0] pc;
        logic        exp_trap;
        logic        exp_fwd;
    } vec_t;

    localparam int NV = 13;
    // Rows: R1 near-misses, R3 window traps, R9 window without pending, R11 follow-on
    localparam vec_t VECS [NV] = '{
        '{7'h73, 3'b001, 12'h345, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 4'd3,  32'h0000_0200, 1'b1, 1'b0},
        '{7'h73, 3'b001, 12'h345, 5'd1, 5'd0, 1'b0, 1'b0, 1'b1, 4'd3,  32'h0000_0204, 1'b0, 1'b1},
        '{7'h73, 3'b001, 12'h345, 5'd0, 5'd2, 1'b0, 1'b0, 1'b1, 4'd3,  32'h0000_0208, 1'b0, 1'b1},
        '{7'h73, 3'b010, 12'h345, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 4'd3,  32'h0000_020C, 1'b0, 1'b1},
        '{7'h73, 3'b101, 12'h345, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 4'd3,  32'h0000_0210, 1'b0, 1'b1},
        '{7'h73, 3'b001, 12'h300, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 4'd3,  32'h0000_0214, 1'b0, 1'b1},
        '{7'h13, 3'b001, 12'h345, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 4'd3,  32'h0000_0218, 1'b0, 1'b0},
        '{7'h73, 3'b000, 12'h345, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 4'd3,  32'h0000_021C, 1'b0, 1'b0},
        '{7'h73, 3'b001, 12'h345, 5'd0, 5'd0, 1'b0, 1'b1, 1'b0, 4'd5,  32'h0000_0220, 1'b0, 1'b0},
        '{7'h73, 3'b001, 12'h345, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 4'd5,  32'h0000_0224, 1'b0, 1'b0},
        '{7'h33, 3'b000, 12'h000, 5'd3, 5'd4, 1'b1, 1'b0, 1'b1, 4'd7,  32'h0000_0228, 1'b1, 1'b0},
        '{7'h73, 3'b001, 12'h345, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 4'd15, 32'hFFFF_FFFC, 1'b1, 1'b0},
        '{7'h33, 3'b000, 12'h000, 5'd3, 5'd4, 1'b0, 1'b0, 1'b1, 4'd15, 32'h0000_0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [6:0]  ret_opcode = '0;
    logic [2:0]  ret_funct3 = '0;
    logic [11:0] ret_csr = '0;
    logic [4:0]  ret_rd = '0;
    logic [4:0]  ret_rs1 = '0;
    logic [31:0] ret_pc = '0;
    logic        ie_in = 1'b0;
    logic        pie_in = 1'b0;
    logic        irq_pending = 1'b0;
    logic [3:0]  irq_cause = '0;
    logic        trap_take, csr_fwd, ie_q, pie_q;
    logic [31:0] next_pc, epc_q, cause_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_epc, m_cause;
    logic        m_ie, m_pie;

    irq_window_trap i_irq_window_trap (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_opcode(ret_opcode),
        .ret_funct3(ret_funct3), .ret_csr(ret_csr), .ret_rd(ret_rd), .ret_rs1(ret_rs1),
        .ret_pc(ret_pc), .ie_in(ie_in), .pie_in(pie_in), .irq_pending(irq_pending),
        .irq_cause(irq_cause), .trap_take(trap_take), .next_pc(next_pc),
        .csr_fwd(csr_fwd), .epc_q(epc_q), .cause_q(cause_q), .ie_q(ie_q), .pie_q(pie_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk("R5", {tag, " epc"}, epc_q, m_epc);
        chk("R7", {tag, " cause"}, cause_q, m_cause);
        chk("R7/R9", {tag, " ie"}, {31'd0, ie_q}, {31'd0, m_ie});
        chk("R6/R9", {tag, " pie"}, {31'd0, pie_q}, {31'd0, m_pie});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        m_epc = '0; m_cause = '0; m_ie = 1'b0; m_pie = 1'b0;
        // R10: reset with inputs that would otherwise load the state
        ie_in = 1'b1; pie_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_regs("R10 reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ret_valid = 1'b1;
            ret_opcode = VECS[i].opc; ret_funct3 = VECS[i].f3; ret_csr = VECS[i].csr;
            ret_rd = VECS[i].rd; ret_rs1 = VECS[i].rs1; ret_pc = VECS[i].pc;
            ie_in = VECS[i].ie; pie_in = VECS[i].pie;
            irq_pending = VECS[i].pend; irq_cause = VECS[i].cause;
            #1;
            chk("R1/R3", $sformatf("vec %0d trap", i), {31'd0, trap_take}, {31'd0, VECS[i].exp_trap});
            chk("R2", $sformatf("vec %0d csr_fwd", i), {31'd0, csr_fwd}, {31'd0, VECS[i].exp_fwd});
            chk("R4/R8", $sformatf("vec %0d next_pc", i), next_pc,
                VECS[i].exp_trap ? BASE : VECS[i].pc + 32'd4);
            if (VECS[i].exp_trap) begin
                m_epc = VECS[i].pc;
                m_cause = {1'b1, 27'd0, VECS[i].cause};
                m_ie = 1'b0;
                m_pie = VECS[i].ie;
            end else begin
                m_ie = VECS[i].ie;
                m_pie = VECS[i].pie;
            end
            @(posedge clk);
            #1;
            check_regs($sformatf("vec %0d", i));
        end

        // R3: no retiring instruction, window fields and pending present -> no trap
        @(negedge clk);
        ret_valid = 1'b0;
        ret_opcode = 7'h73; ret_funct3 = 3'b001; ret_csr = 12'h345;
        ret_rd = 5'd0; ret_rs1 = 5'd0; ret_pc = 32'h300;
        ie_in = 1'b0; pie_in = 1'b0; irq_pending = 1'b1; irq_cause = 4'd9;
        #1;
        chk("R3", "invalid slot trap", {31'd0, trap_take}, 32'd0);
        chk("R2", "invalid slot csr_fwd", {31'd0, csr_fwd}, 32'd0);
        m_ie = 1'b0; m_pie = 1'b0;
        @(posedge clk);
        #1;
        check_regs("R9 invalid slot hold");

        // R10: reset in mid-run clears captured state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m_epc = '0; m_cause = '0; m_ie = 1'b0; m_pie = 1'b0;
        check_regs("R10 mid-run reset");

        finish_run();
    end

endmodule